// File: doc/BRIEF.md
# Byte-Lane PCI I/O Initiator

This block sits in a processor's memory map and lets software issue single PCI I/O transactions whose byte enables select exactly one byte lane. The processor's own PCI port cannot do this. Software loads a target address and, for a write, a data word. It then writes a command code into the command register. The block runs one 32-bit transaction: an address phase, a single data phase held until the target answers, then a return to idle. The command register also drives two IDSEL lines (processor side and disk controller side) and the PCI reset line. It holds a read-only idle flag, which software polls before it uses the read data or starts the next access.

The two low bits of the target address choose the byte lane. A target that signals retry causes the whole transaction to be run again. If no target claims the cycle within a fixed number of data-phase clocks, the attempt is a master abort and a read returns all ones. Software drives the PCI reset sequence by setting the reset bit, waiting about 1 ms and clearing it again.

Top module: `byte_io_initiator`

## Requirements
- R1: After reset, FRAME# and IRDY# are high, AD is not driven, PCI reset and both IDSEL outputs are inactive, and the command register reads 0x0001_0000 (only the idle flag, bit 16, set).
- R2: Registers are selected by host offset: 0x60000 command, 0x68000 address, 0x70000 write data, 0x78000 read data. The address and write data registers read back what was written.
- R3: Command bit 12 drives `idsel_host`, bit 13 drives `idsel_disk`, and bit 15 set drives `pci_rst_n` low.
- R4: Writing command code 0x2 (I/O read) or 0x3 (I/O write) to bits [3:0] while idle starts a transaction. In the next cycle FRAME# is low, AD carries the full address, C/BE# carries the code, and the idle flag reads 0. FRAME# stays low for one clock only.
- R5: In the data phase FRAME# is high, IRDY# is low, and C/BE# is active-low one-hot by address bits [1:0]: 00→4'b1110, 01→4'b1101, 10→4'b1011, 11→4'b0111.
- R6: During the data phase of an I/O write, AD is driven with the write data register. During an I/O read, AD is not driven.
- R7: The data phase ends on the clock edge where TRDY# is sampled low. On the next cycle IRDY# is high and the block is idle, and for a read the read data register holds the AD value sampled at that edge.
- R8: STOP# low with TRDY# high ends the attempt. One clock with FRAME# and IRDY# high follows, then the same address phase repeats.
- R9: If DEVSEL# stays high for 5 data-phase clocks, the transaction ends as a master abort after exactly 5 data clocks, and a read returns 0xFFFF_FFFF.
- R10: Any register write while the block is not idle has no effect: IDSEL, reset and the stored address are unchanged, and no new transaction starts.
- R11: A command write whose code is neither 0x2 nor 0x3 updates bits 12, 13 and 15 but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HADDR_W | Host byte offset from the block's base |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| pci_ad_out | output | 32 | AD value to drive |
| pci_ad_oe | output | 1 | AD output enable |
| pci_ad_in | input | 32 | AD value seen on the bus |
| pci_cbe_n | output | 4 | Command / byte enables, active low |
| pci_frame_n | output | 1 | FRAME# |
| pci_irdy_n | output | 1 | IRDY# |
| pci_trdy_n | input | 1 | TRDY# from the target |
| pci_devsel_n | input | 1 | DEVSEL# from the target |
| pci_stop_n | input | 1 | STOP# from the target |
| pci_rst_n | output | 1 | PCI reset, active low |
| idsel_host | output | 1 | IDSEL for the processor's PCI port |
| idsel_disk | output | 1 | IDSEL for the disk controller |

## Verification
The bench drives each of the four byte lanes. A lane decoder that is off by one or inverted would put the wrong one-hot enable on C/BE# in the data phase. A scripted target inserts wait states, answers one attempt with a retry, and stays silent to force a master abort. A design that took STOP# as completion would latch stale read data. A design that miscounted the timeout would end after the wrong number of data clocks or return something other than all ones. Register writes are also sent while a transaction is in flight. A design that accepted them would change IDSEL, the address, or start a second data phase.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ADDR  = 2'd1,
    SQ_DATA  = 2'd2,
    SQ_RETRY = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    RS_CMD   = 2'd0,
    RS_ADDR  = 2'd1,
    RS_WDATA = 2'd2,
    RS_RDATA = 2'd3
  } reg_sel_t;

  localparam logic [3:0] CODE_IO_RD = 4'h2;
  localparam logic [3:0] CODE_IO_WR = 4'h3;

  localparam int unsigned BIT_IDSEL_HOST = 12;
  localparam int unsigned BIT_IDSEL_DISK = 13;
  localparam int unsigned BIT_RESET      = 15;
  localparam int unsigned BIT_IDLE       = 16;

  function automatic logic [3:0] lane_enable_n(input logic [1:0] lo);
    return ~(4'b0001 << lo);
  endfunction

  function automatic logic is_io_code(input logic [3:0] code);
    return (code == CODE_IO_RD) || (code == CODE_IO_WR);
  endfunction
endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned HADDR_W  = 20,
  parameter logic [HADDR_W-1:0] REG_BASE = HADDR_W'(20'h60000),
  parameter int unsigned SEL_LSB  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic [BUS_W-1:0]   host_rdata,
  input  logic               idle,
  input  logic               rd_capture,
  input  logic [BUS_W-1:0]   rd_value,
  output logic [3:0]         cmd_code,
  output logic [BUS_W-1:0]   addr_q,
  output logic [BUS_W-1:0]   wdata_q,
  output logic               idsel_h_q,
  output logic               idsel_d_q,
  output logic               reset_q,
  output logic               start_evt
);
  localparam int unsigned BLK_LSB = SEL_LSB + 2;

  logic           hit;
  reg_sel_t       sel;
  logic           wr_ok;
  logic [BUS_W-1:0] rd_q;

  assign hit   = (host_addr[HADDR_W-1:BLK_LSB] == REG_BASE[HADDR_W-1:BLK_LSB]) &&
                 (host_addr[SEL_LSB-1:0] == '0);
  assign sel   = reg_sel_t'(host_addr[SEL_LSB+1:SEL_LSB]);
  assign wr_ok = host_wr && hit && idle;
  assign start_evt = wr_ok && (sel == RS_CMD) && is_io_code(host_wdata[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code  <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      idsel_h_q <= 1'b0;
      idsel_d_q <= 1'b0;
      reset_q   <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (wr_ok) begin
        unique case (sel)
          RS_CMD: begin
            cmd_code  <= host_wdata[3:0];
            idsel_h_q <= host_wdata[BIT_IDSEL_HOST];
            idsel_d_q <= host_wdata[BIT_IDSEL_DISK];
            reset_q   <= host_wdata[BIT_RESET];
          end
          RS_ADDR:  addr_q  <= host_wdata;
          RS_WDATA: wdata_q <= host_wdata;
          default: ;
        endcase
      end
      if (rd_capture) rd_q <= rd_value;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (hit) begin
      unique case (sel)
        RS_CMD: begin
          host_rdata[3:0]            = cmd_code;
          host_rdata[BIT_IDSEL_HOST] = idsel_h_q;
          host_rdata[BIT_IDSEL_DISK] = idsel_d_q;
          host_rdata[BIT_RESET]      = reset_q;
          host_rdata[BIT_IDLE]       = idle;
        end
        RS_ADDR:  host_rdata = addr_q;
        RS_WDATA: host_rdata = wdata_q;
        default:  host_rdata = rd_q;
      endcase
    end
  end
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int unsigned DEVSEL_TIMEOUT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic [3:0]       cmd_code,
  input  logic [BUS_W-1:0] addr_q,
  input  logic [BUS_W-1:0] wdata_q,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic [3:0]       cbe_n,
  output logic             idle,
  output logic             rd_capture,
  output logic [BUS_W-1:0] rd_value,
  output logic             done_evt,
  output logic             retry_evt,
  output logic             abort_evt
);
  localparam int unsigned TO_W = $clog2(DEVSEL_TIMEOUT + 1);

  seq_state_t      state;
  logic [TO_W-1:0] to_cnt;
  logic            claimed;
  logic            in_data;
  logic            is_read;

  assign in_data   = (state == SQ_DATA);
  assign is_read   = (cmd_code == CODE_IO_RD);
  assign done_evt  = in_data && !trdy_n;
  assign retry_evt = in_data && trdy_n && !stop_n;
  assign abort_evt = in_data && trdy_n && stop_n && !claimed && devsel_n &&
                     (to_cnt == TO_W'(DEVSEL_TIMEOUT - 1));
  assign idle      = (state == SQ_IDLE);

  assign rd_capture = is_read && (done_evt || abort_evt);
  assign rd_value   = done_evt ? ad_in : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      to_cnt  <= '0;
      claimed <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE:  if (start_evt) state <= SQ_ADDR;
        SQ_ADDR: begin
          state   <= SQ_DATA;
          to_cnt  <= '0;
          claimed <= 1'b0;
        end
        SQ_DATA: begin
          if (done_evt || abort_evt) state <= SQ_IDLE;
          else if (retry_evt)        state <= SQ_RETRY;
          else if (!devsel_n)        claimed <= 1'b1;
          else if (!claimed)         to_cnt <= to_cnt + 1'b1;
        end
        default: state <= SQ_ADDR;
      endcase
    end
  end

  always_comb begin
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    ad_out  = '0;
    ad_oe   = 1'b0;
    cbe_n   = 4'hF;
    unique case (state)
      SQ_ADDR: begin
        frame_n = 1'b0;
        ad_out  = addr_q;
        ad_oe   = 1'b1;
        cbe_n   = cmd_code;
      end
      SQ_DATA: begin
        irdy_n = 1'b0;
        cbe_n  = lane_enable_n(addr_q[1:0]);
        ad_out = wdata_q;
        ad_oe  = !is_read;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_io_initiator.sv
module byte_io_initiator
  import pio_pkg::*;
#(
  parameter int unsigned HADDR_W        = 20,
  parameter int unsigned DEVSEL_TIMEOUT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic [31:0]        pci_ad_out,
  output logic               pci_ad_oe,
  input  logic [31:0]        pci_ad_in,
  output logic [3:0]         pci_cbe_n,
  output logic               pci_frame_n,
  output logic               pci_irdy_n,
  input  logic               pci_trdy_n,
  input  logic               pci_devsel_n,
  input  logic               pci_stop_n,
  output logic               pci_rst_n,
  output logic               idsel_host,
  output logic               idsel_disk
);
  logic             seq_idle;
  logic             start_evt;
  logic             done_evt;
  logic             retry_evt;
  logic             abort_evt;
  logic             rd_capture;
  logic [BUS_W-1:0] rd_value;
  logic [3:0]       cmd_code;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] wdata_q;
  logic             reset_q;

  pio_regs #(.HADDR_W(HADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .idle(seq_idle),
    .rd_capture(rd_capture), .rd_value(rd_value),
    .cmd_code(cmd_code), .addr_q(addr_q), .wdata_q(wdata_q),
    .idsel_h_q(idsel_host), .idsel_d_q(idsel_disk), .reset_q(reset_q),
    .start_evt(start_evt)
  );

  pio_seq #(.DEVSEL_TIMEOUT(DEVSEL_TIMEOUT)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .cmd_code(cmd_code),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .trdy_n(pci_trdy_n), .devsel_n(pci_devsel_n), .stop_n(pci_stop_n),
    .ad_in(pci_ad_in),
    .frame_n(pci_frame_n), .irdy_n(pci_irdy_n),
    .ad_out(pci_ad_out), .ad_oe(pci_ad_oe), .cbe_n(pci_cbe_n),
    .idle(seq_idle), .rd_capture(rd_capture), .rd_value(rd_value),
    .done_evt(done_evt), .retry_evt(retry_evt), .abort_evt(abort_evt)
  );

  assign pci_rst_n = !reset_q;
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
  parameter int unsigned DEVSEL_TIMEOUT = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       trdy_n,
  input logic       devsel_n,
  input logic       stop_n,
  input logic [3:0] cbe_n,
  input logic       idle,
  input logic       idsel_h,
  input logic       idsel_d,
  input logic       prst_n,
  input logic       start_evt,
  input logic       abort_evt
);
  localparam int unsigned CW = $clog2(DEVSEL_TIMEOUT + 2);
  logic [CW-1:0] silent_cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n || irdy_n) begin
      silent_cnt <= '0;
      seen       <= 1'b0;
    end else if (!devsel_n) begin
      seen <= 1'b1;
    end else if (!seen) begin
      silent_cnt <= silent_cnt + 1'b1;
    end
  end

  a_r4_start_frame: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !frame_n);
  a_r4_frame_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n);
  a_r5_irdy_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !irdy_n);
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !irdy_n |-> ($countones(~cbe_n) == 1));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n) |=> (irdy_n && idle));
  a_r8_retry_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && !stop_n) |=> (irdy_n && frame_n && !idle));
  a_r9_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    silent_cnt <= CW'(DEVSEL_TIMEOUT));
  a_r9_abort_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> (silent_cnt == CW'(DEVSEL_TIMEOUT - 1)));
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable({idsel_h, idsel_d, prst_n}));
endmodule

bind byte_io_initiator pio_checker #(.DEVSEL_TIMEOUT(DEVSEL_TIMEOUT)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .frame_n(pci_frame_n), .irdy_n(pci_irdy_n), .trdy_n(pci_trdy_n),
  .devsel_n(pci_devsel_n), .stop_n(pci_stop_n), .cbe_n(pci_cbe_n),
  .idle(seq_idle), .idsel_h(idsel_host), .idsel_d(idsel_disk),
  .prst_n(pci_rst_n), .start_evt(start_evt), .abort_evt(abort_evt)
);

// File: tb/byte_io_initiator_tb_top.sv
module byte_io_initiator_tb_top;
  localparam int HW = 20;
  localparam logic [HW-1:0] OFS_CMD = 20'h60000, OFS_ADDR = 20'h68000,
                            OFS_WDAT = 20'h70000, OFS_RDAT = 20'h78000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] host_addr = '0;
  logic host_wr = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [31:0] ad_out, ad_in = '0;
  logic ad_oe, frame_n, irdy_n, prst_n, id_h, id_d;
  logic [3:0] cbe_n;
  logic trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  int tgt_mode = 0, tgt_wait = 1, dcnt = 0, data_cycles = 0;
  bit retried = 0;
  logic [31:0] tgt_data = '0;

  typedef struct { logic [3:0] cbe; logic [31:0] ad; logic oe; } phase_t;
  phase_t exp_q[$];

  always #4 clk = ~clk;

  byte_io_initiator #(.HADDR_W(HW), .DEVSEL_TIMEOUT(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pci_ad_out(ad_out), .pci_ad_oe(ad_oe), .pci_ad_in(ad_in),
    .pci_cbe_n(cbe_n), .pci_frame_n(frame_n), .pci_irdy_n(irdy_n),
    .pci_trdy_n(trdy_n), .pci_devsel_n(devsel_n), .pci_stop_n(stop_n),
    .pci_rst_n(prst_n), .idsel_host(id_h), .idsel_disk(id_d));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scripted target: drives at negedge, the design samples at posedge
  always @(negedge clk) begin
    if (!irdy_n) begin
      dcnt++;
      devsel_n = (tgt_mode == 2);
      if (tgt_mode == 1 && !retried) begin
        stop_n = 1'b0; trdy_n = 1'b1; retried = 1;
      end else if (tgt_mode != 2 && dcnt >= tgt_wait) begin
        trdy_n = 1'b0; stop_n = 1'b1; ad_in = tgt_data;
      end else begin
        trdy_n = 1'b1; stop_n = 1'b1;
      end
    end else begin
      dcnt = 0; trdy_n = 1'b1; devsel_n = 1'b1; stop_n = 1'b1; ad_in = '0;
    end
  end

  // monitor: pops the scoreboard at each completed data phase
  always @(negedge clk) begin
    #2;
    if (!irdy_n) data_cycles++;
    if (!irdy_n && !trdy_n) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected data phase completion", {28'd0, cbe_n}, 32'd0);
      else begin
        phase_t e;
        e = exp_q.pop_front();
        check(cbe_n == e.cbe, "R5 data phase byte enables", {28'd0, cbe_n}, {28'd0, e.cbe});
        check(ad_oe == e.oe, "R6 AD drive enable", {31'd0, ad_oe}, {31'd0, e.oe});
        if (e.oe) check(ad_out == e.ad, "R6 write data on AD", ad_out, e.ad);
      end
    end
  end

  task automatic reg_write(input logic [HW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [HW-1:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reg_read(OFS_CMD, v);
      if (v[16]) return;
    end
    check(0, "R7 idle flag never returned", 32'd0, 32'd1);
  endtask

  // one I/O transaction with address/data phase checks
  task automatic io_access(input logic [3:0] code, input logic [31:0] a, input logic [31:0] wd,
                           input int mode, input int wt, input logic [31:0] td,
                           input logic [31:0] ctl);
    logic [31:0] v;
    phase_t e;
    tgt_mode = mode; tgt_wait = wt; tgt_data = td; retried = 0;
    reg_write(OFS_ADDR, a);
    reg_write(OFS_WDAT, wd);
    data_cycles = 0;
    e.cbe = ~(4'b0001 << a[1:0]); e.ad = wd; e.oe = (code == 4'h3);
    if (mode != 2) exp_q.push_back(e);
    reg_write(OFS_CMD, ctl | {28'd0, code});
    check(frame_n == 1'b0, "R4 FRAME# low in address phase", {31'd0, frame_n}, 32'd0);
    check(ad_out == a && ad_oe, "R4 address on AD", ad_out, a);
    check(cbe_n == code, "R4 command on C/BE#", {28'd0, cbe_n}, {28'd0, code});
    reg_read(OFS_CMD, v);
    check(v[16] == 1'b0, "R4 idle flag clear while busy", v, 32'd0);
    @(negedge clk);
    check(frame_n && !irdy_n, "R5 FRAME# high IRDY# low in data phase",
          {30'd0, frame_n, irdy_n}, 32'd2);
    check(cbe_n == e.cbe, "R5 one-hot lane at data start", {28'd0, cbe_n}, {28'd0, e.cbe});
    check(ad_oe == e.oe, "R6 AD enable matches direction", {31'd0, ad_oe}, {31'd0, e.oe});
    wait_idle();
  endtask

  initial begin
    #(8 * 200000);
    check(0, "R1 watchdog expired", 32'd0, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frame_n && irdy_n && !ad_oe, "R1 bus released after reset",
          {29'd0, frame_n, irdy_n, ad_oe}, 32'd6);
    check(prst_n && !id_h && !id_d, "R1 controls inactive", {29'd0, prst_n, id_h, id_d}, 32'd4);
    reg_read(OFS_CMD, v);
    check(v == 32'h0001_0000, "R1 command register reset value", v, 32'h0001_0000);

    // R2 register offsets and readback
    reg_write(OFS_ADDR, 32'h1234_5678);
    reg_write(OFS_WDAT, 32'hCAFE_0042);
    reg_read(OFS_ADDR, v); check(v == 32'h1234_5678, "R2 address readback", v, 32'h1234_5678);
    reg_read(OFS_WDAT, v); check(v == 32'hCAFE_0042, "R2 write data readback", v, 32'hCAFE_0042);

    // R3 and R11: controls with a non-I/O code
    reg_write(OFS_CMD, 32'h0000_B000);
    check(id_h && id_d && !prst_n, "R3 IDSEL and reset bits drive pins",
          {29'd0, id_h, id_d, prst_n}, 32'd6);
    check(frame_n, "R11 code 0 starts no transaction", {31'd0, frame_n}, 32'd1);
    reg_read(OFS_CMD, v);
    check(v == 32'h0001_B000, "R11 command readback idle", v, 32'h0001_B000);
    reg_write(OFS_CMD, 32'h0000_100A);
    check(frame_n && prst_n && id_h && !id_d, "R11 code 0xA only updates controls",
          {28'd0, frame_n, prst_n, id_h, id_d}, 32'hE);

    // R4-R7 writes on every byte lane
    for (int ln = 0; ln < 4; ln++)
      io_access(4'h3, 32'h0000_1F0 + ln, 32'h11 << (8 * ln), 0, 1 + ln, '0, 32'h1000);
    check(exp_q.size() == 0, "R7 all write phases completed", exp_q.size(), 0);

    // R7 read with wait states
    io_access(4'h2, 32'h0000_3F5, '0, 0, 3, 32'hA5A5_1234, 32'h1000);
    reg_read(OFS_RDAT, v);
    check(v == 32'hA5A5_1234, "R7 read data captured", v, 32'hA5A5_1234);
    check(data_cycles == 3, "R7 data phase length with waits", data_cycles, 3);

    // R8 retry then success
    io_access(4'h2, 32'h0000_3F6, '0, 1, 1, 32'h0BAD_F00D, 32'h1000);
    reg_read(OFS_RDAT, v);
    check(v == 32'h0BAD_F00D, "R8 read data after retry", v, 32'h0BAD_F00D);
    check(data_cycles == 2, "R8 two data phases on retry", data_cycles, 2);

    // R9 master abort
    io_access(4'h2, 32'h0000_3F7, '0, 2, 1, 32'h0, 32'h1000);
    reg_read(OFS_RDAT, v);
    check(v == 32'hFFFF_FFFF, "R9 abort returns all ones", v, 32'hFFFF_FFFF);
    check(data_cycles == 5, "R9 abort after five data clocks", data_cycles, 5);

    // R10 writes while busy are ignored
    begin
      phase_t e;
      tgt_mode = 0; tgt_wait = 12; tgt_data = 32'h5566_7788; retried = 0;
      reg_write(OFS_ADDR, 32'h0000_0402);
      data_cycles = 0;
      e.cbe = 4'b1011; e.ad = '0; e.oe = 1'b0;
      exp_q.push_back(e);
      reg_write(OFS_CMD, 32'h0000_1002);
      reg_write(OFS_CMD, 32'h0000_A003);
      reg_write(OFS_ADDR, 32'h0000_0403);
      check(id_h && !id_d && prst_n, "R10 controls frozen while busy",
            {29'd0, id_h, id_d, prst_n}, 32'd5);
      wait_idle();
      reg_read(OFS_ADDR, v);
      check(v == 32'h0000_0402, "R10 address write ignored while busy", v, 32'h0000_0402);
      reg_read(OFS_RDAT, v);
      check(v == 32'h5566_7788, "R10 original read completes", v, 32'h5566_7788);
      repeat (3) @(negedge clk);
      check(frame_n && data_cycles == 12, "R10 no second transaction",
            data_cycles, 12);
      check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    end
    finish_run();
  end
endmodule